// File: doc/BRIEF.md
# Timer Channel Context Selector

This block holds the per-channel state that a small timer microengine works on: two capture inputs, two match registers, four latched event flags (match recognition A/B, transition detect A/B) and one output pin for each channel. It also holds two engine-side event registers and the current channel number. In each cycle a microinstruction may do any mix of the following: move to another channel, load the event registers from the captures, copy the event registers into the match registers, clear latched flags and drive a pin action.

When the channel number changes in the same cycle as another action, each action follows its own fixed rule about which channel it uses. Captures are read from the new channel. Match writes go to the new channel and carry the event-register contents from before the cycle. Flag clears and pin actions act on the old channel. The branch-condition outputs show the flags of the new channel. The engine sees the branch outputs combinationally in the cycle that it issues the instruction, so it can branch on the state of the channel it is moving to.

Top module: `chan_ctx_sel`

## Requirements
- R1: While rst_n is low, the channel number, both event registers, every match register, every flag and every pin output are zero.
- R2: When chan_wr is high, chan takes chan_new at the clock edge. Otherwise chan holds its value.
- R3: When rd_match is high, ert_a and ert_b load capture A and B of the effective channel. The effective channel is chan_new when chan_wr is high and chan otherwise. When rd_match is low, both event registers hold.
- R4: When wr_event is high, match A and B of the effective channel load ert_a and ert_b. Match registers of all other channels keep their values.
- R5: When rd_match and wr_event are high together, the match registers receive the event-register values from before the edge, and the event registers receive the new captures.
- R6: clr_mrl clears both match-recognition flags, and clr_tdl clears both transition-detect flags, of the channel held in chan before the edge, even when chan_wr is high.
- R7: br_mrl_a, br_mrl_b, br_tdl_a and br_tdl_b show the registered flags of the effective channel, as they were before this cycle's sets and clears.
- R8: A flag whose set input is high in the same cycle as a clear of that flag ends set.
- R9: pin_act acts on the pin of the channel held in chan before the edge. The encoding is 2'b00 no change, 2'b01 drive high, 2'b10 drive low and 2'b11 toggle. All other pins hold.
- R10: A flag set input latches its channel's flag whatever the current channel is. The flag then stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_wr | input | 1 | Assign a new channel number this cycle |
| chan_new | input | 5 | New channel number |
| rd_match | input | 1 | Load event registers from the captures |
| wr_event | input | 1 | Write event registers into the match registers |
| clr_mrl | input | 1 | Clear match-recognition flags of the old channel |
| clr_tdl | input | 1 | Clear transition-detect flags of the old channel |
| pin_act | input | 2 | Pin action on the old channel |
| cap_a_in | input | 768 | Capture A of every channel, channel i in bits [24i+23:24i] |
| cap_b_in | input | 768 | Capture B of every channel, same layout |
| mrl_a_set | input | 32 | Per-channel set of match-recognition flag A |
| mrl_b_set | input | 32 | Per-channel set of match-recognition flag B |
| tdl_a_set | input | 32 | Per-channel set of transition-detect flag A |
| tdl_b_set | input | 32 | Per-channel set of transition-detect flag B |
| chan | output | 5 | Current channel number |
| ert_a | output | 24 | Event register A |
| ert_b | output | 24 | Event register B |
| match_a | output | 768 | Match A of every channel, same layout as cap_a_in |
| match_b | output | 768 | Match B of every channel |
| pin_out | output | 32 | Output pin of every channel |
| br_mrl_a | output | 1 | Branch condition: match-recognition flag A of the effective channel |
| br_mrl_b | output | 1 | Branch condition: match-recognition flag B |
| br_tdl_a | output | 1 | Branch condition: transition-detect flag A |
| br_tdl_b | output | 1 | Branch condition: transition-detect flag B |

## Verification
If a same-cycle action is bound to the wrong channel, the error reaches the ports one edge later. A misrouted match write or pin action changes another channel's match_a/match_b slice or pin_out bit. A capture read from the wrong channel shows up at once in ert_a/ert_b. A flag cleared on the wrong channel only becomes visible when a later cycle selects that channel and reads the branch outputs. For that reason the reference model compares every output on every cycle under random channel hopping, so that stale or missing flags are caught the first time they are read.

// File: rtl/chan_ctx_sel.sv
module chan_ctx_sel #(
  parameter int NCH = 32,
  parameter int DW  = 24,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_wr,
  input  logic [CW-1:0]     chan_new,
  input  logic              rd_match,
  input  logic              wr_event,
  input  logic              clr_mrl,
  input  logic              clr_tdl,
  input  logic [1:0]        pin_act,
  input  logic [NCH*DW-1:0] cap_a_in,
  input  logic [NCH*DW-1:0] cap_b_in,
  input  logic [NCH-1:0]    mrl_a_set,
  input  logic [NCH-1:0]    mrl_b_set,
  input  logic [NCH-1:0]    tdl_a_set,
  input  logic [NCH-1:0]    tdl_b_set,
  output logic [CW-1:0]     chan,
  output logic [DW-1:0]     ert_a,
  output logic [DW-1:0]     ert_b,
  output logic [NCH*DW-1:0] match_a,
  output logic [NCH*DW-1:0] match_b,
  output logic [NCH-1:0]    pin_out,
  output logic              br_mrl_a,
  output logic              br_mrl_b,
  output logic              br_tdl_a,
  output logic              br_tdl_b
);

  logic [CW-1:0]  eff;
  logic [NCH-1:0] old_oh, clr_m, clr_t;
  logic [NCH-1:0] mrl_a, mrl_b, tdl_a, tdl_b;
  logic [DW-1:0]  mat_a [NCH];
  logic [DW-1:0]  mat_b [NCH];

  assign eff    = chan_wr ? chan_new : chan;
  assign old_oh = NCH'(1) << chan;
  assign clr_m  = clr_mrl ? old_oh : '0;
  assign clr_t  = clr_tdl ? old_oh : '0;

  assign br_mrl_a = mrl_a[eff];
  assign br_mrl_b = mrl_b[eff];
  assign br_tdl_a = tdl_a[eff];
  assign br_tdl_b = tdl_b[eff];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan  <= '0;
      ert_a <= '0;
      ert_b <= '0;
    end else begin
      if (chan_wr)  chan <= chan_new;
      if (rd_match) begin
        ert_a <= cap_a_in[eff*DW +: DW];
        ert_b <= cap_b_in[eff*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrl_a <= '0;
      mrl_b <= '0;
      tdl_a <= '0;
      tdl_b <= '0;
    end else begin
      mrl_a <= mrl_a_set | (mrl_a & ~clr_m);
      mrl_b <= mrl_b_set | (mrl_b & ~clr_m);
      tdl_a <= tdl_a_set | (tdl_a & ~clr_t);
      tdl_b <= tdl_b_set | (tdl_b & ~clr_t);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= '0;
    else begin
      case (pin_act)
        2'b01:   pin_out <= pin_out | old_oh;
        2'b10:   pin_out <= pin_out & ~old_oh;
        2'b11:   pin_out <= pin_out ^ old_oh;
        default: pin_out <= pin_out;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mat_a[i] <= '0;
        mat_b[i] <= '0;
      end else if (wr_event && eff == CW'(i)) begin
        mat_a[i] <= ert_a;
        mat_b[i] <= ert_b;
      end
    end
    assign match_a[i*DW +: DW] = mat_a[i];
    assign match_b[i*DW +: DW] = mat_b[i];
  end

endmodule

// File: rtl/chan_ctx_sel_chk.sv
module chan_ctx_sel_chk #(
  parameter int NCH = 32,
  parameter int DW  = 24,
  localparam int CW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_wr,
  input logic [CW-1:0]     chan_new,
  input logic              rd_match,
  input logic              wr_event,
  input logic [1:0]        pin_act,
  input logic [NCH*DW-1:0] cap_a_in,
  input logic [CW-1:0]     chan,
  input logic [DW-1:0]     ert_a,
  input logic [NCH*DW-1:0] match_a,
  input logic [NCH-1:0]    pin_out
);

  logic [CW-1:0] sel, sel_q, old_q;
  logic          rd_q, wr_q, pin_prev_q;
  logic [1:0]    act_q;
  logic [DW-1:0] cap_q, ert_q;

  assign sel = chan_wr ? chan_new : chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; old_q <= '0; rd_q <= 1'b0; wr_q <= 1'b0;
      act_q <= '0; cap_q <= '0; ert_q <= '0; pin_prev_q <= 1'b0;
    end else begin
      sel_q      <= sel;
      old_q      <= chan;
      rd_q       <= rd_match;
      wr_q       <= wr_event;
      act_q      <= pin_act;
      cap_q      <= cap_a_in[sel*DW +: DW];
      ert_q      <= ert_a;
      pin_prev_q <= pin_out[chan];
    end
  end

  // R2
  chan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> chan == $past(chan_new));
  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_wr |=> $stable(chan));
  // R3
  ert_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> ert_a == cap_q);
  // R3
  ert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_match |=> $stable(ert_a));
  // R4
  match_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> match_a[sel_q*DW +: DW] == ert_q);
  // R9
  pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == 2'b01 |-> pin_out[old_q]);
  // R9
  pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == 2'b10 |-> !pin_out[old_q]);
  // R9
  pin_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == 2'b11 |-> pin_out[old_q] != pin_prev_q);

endmodule

bind chan_ctx_sel chan_ctx_sel_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr), .chan_new(chan_new),
  .rd_match(rd_match), .wr_event(wr_event), .pin_act(pin_act),
  .cap_a_in(cap_a_in), .chan(chan), .ert_a(ert_a), .match_a(match_a),
  .pin_out(pin_out)
);

// File: tb/tb_chan_ctx_sel.sv
module tb_chan_ctx_sel;
  localparam int NCH = 32;
  localparam int DW  = 24;

  logic clk = 0, rst_n = 0;
  logic chan_wr = 0, rd_match = 0, wr_event = 0, clr_mrl = 0, clr_tdl = 0;
  logic [4:0] chan_new = 0;
  logic [1:0] pin_act = 0;
  logic [NCH*DW-1:0] cap_a_in = 0, cap_b_in = 0;
  logic [NCH-1:0] mrl_a_set = 0, mrl_b_set = 0, tdl_a_set = 0, tdl_b_set = 0;
  logic [4:0] chan;
  logic [DW-1:0] ert_a, ert_b;
  logic [NCH*DW-1:0] match_a, match_b;
  logic [NCH-1:0] pin_out;
  logic br_mrl_a, br_mrl_b, br_tdl_a, br_tdl_b;

  chan_ctx_sel dut (.*);

  always #4 clk = ~clk;

  int vecs = 0, bad = 0;
  bit done = 0;

  int m_chan;
  logic [DW-1:0] m_ea, m_eb;
  logic [DW-1:0] m_ma [NCH];
  logic [DW-1:0] m_mb [NCH];
  bit m_fa [NCH], m_fb [NCH], m_ta [NCH], m_tb [NCH];
  bit m_pin [NCH];

  task automatic chk(string tag, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs(string tag1);
    int mis_a = -1, mis_b = -1, mis_p = -1;
    chk({tag1, " R2 chan"}, chan, m_chan);
    chk("R3 R5 ert_a", ert_a, m_ea);
    chk("R3 R5 ert_b", ert_b, m_eb);
    for (int i = 0; i < NCH; i++) begin
      if (mis_a < 0 && match_a[i*DW +: DW] !== m_ma[i]) mis_a = i;
      if (mis_b < 0 && match_b[i*DW +: DW] !== m_mb[i]) mis_b = i;
      if (mis_p < 0 && pin_out[i] !== m_pin[i]) mis_p = i;
    end
    if (mis_a < 0) chk("R4 match_a", 0, 0);
    else chk("R4 match_a", match_a[mis_a*DW +: DW], m_ma[mis_a]);
    if (mis_b < 0) chk("R4 match_b", 0, 0);
    else chk("R4 match_b", match_b[mis_b*DW +: DW], m_mb[mis_b]);
    if (mis_p < 0) chk("R9 pin_out", 0, 0);
    else chk("R9 pin_out", pin_out[mis_p], m_pin[mis_p]);
  endtask

  task automatic check_br();
    int e = chan_wr ? int'(chan_new) : m_chan;
    chk("R7 R10 br_mrl_a", br_mrl_a, m_fa[e]);
    chk("R7 R10 br_mrl_b", br_mrl_b, m_fb[e]);
    chk("R6 R8 br_tdl_a", br_tdl_a, m_ta[e]);
    chk("R6 R8 br_tdl_b", br_tdl_b, m_tb[e]);
  endtask

  task automatic model_step();
    int e = chan_wr ? int'(chan_new) : m_chan;
    int o = m_chan;
    if (wr_event) begin
      m_ma[e] = m_ea;
      m_mb[e] = m_eb;
    end
    if (rd_match) begin
      m_ea = cap_a_in[e*DW +: DW];
      m_eb = cap_b_in[e*DW +: DW];
    end
    for (int i = 0; i < NCH; i++) begin
      if (clr_mrl && i == o) begin m_fa[i] = 0; m_fb[i] = 0; end
      if (clr_tdl && i == o) begin m_ta[i] = 0; m_tb[i] = 0; end
      if (mrl_a_set[i]) m_fa[i] = 1;
      if (mrl_b_set[i]) m_fb[i] = 1;
      if (tdl_a_set[i]) m_ta[i] = 1;
      if (tdl_b_set[i]) m_tb[i] = 1;
    end
    case (pin_act)
      2'b01: m_pin[o] = 1;
      2'b10: m_pin[o] = 0;
      2'b11: m_pin[o] = !m_pin[o];
      default: ;
    endcase
    if (chan_wr) m_chan = chan_new;
  endtask

  task automatic cycle();
    #1;
    check_br();
    model_step();
    @(negedge clk);
    check_regs("cyc");
  endtask

  task automatic rand_caps();
    for (int i = 0; i < NCH; i++) begin
      cap_a_in[i*DW +: DW] = DW'($urandom);
      cap_b_in[i*DW +: DW] = DW'($urandom);
    end
  endtask

  task automatic idle();
    chan_wr = 0; rd_match = 0; wr_event = 0; clr_mrl = 0; clr_tdl = 0;
    pin_act = 0; mrl_a_set = 0; mrl_b_set = 0; tdl_a_set = 0; tdl_b_set = 0;
  endtask

  initial begin
    m_chan = 0; m_ea = 0; m_eb = 0;
    for (int i = 0; i < NCH; i++) begin
      m_ma[i] = 0; m_mb[i] = 0; m_fa[i] = 0; m_fb[i] = 0;
      m_ta[i] = 0; m_tb[i] = 0; m_pin[i] = 0;
    end
    rand_caps();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_regs("R1 reset");
    check_br();
    rst_n = 1;

    // R5: load then swap with channel change in one cycle
    idle(); rd_match = 1; chan_wr = 1; chan_new = 5'd7; cycle();
    idle(); rand_caps(); rd_match = 1; wr_event = 1; chan_wr = 1; chan_new = 5'd3; cycle();
    // R10 R6 R8: set flags on 3, then clear from 3 while moving to 9 with a same-cycle set
    idle(); mrl_a_set[3] = 1; tdl_b_set[3] = 1; mrl_a_set[9] = 1; cycle();
    idle(); clr_mrl = 1; clr_tdl = 1; chan_wr = 1; chan_new = 5'd9; mrl_a_set[3] = 1; cycle();
    idle(); chan_wr = 1; chan_new = 5'd3; cycle();
    // R9: pin actions with channel change
    idle(); pin_act = 2'b01; chan_wr = 1; chan_new = 5'd31; cycle();
    idle(); pin_act = 2'b11; chan_wr = 1; chan_new = 5'd0; cycle();
    idle(); pin_act = 2'b11; cycle();
    idle(); pin_act = 2'b10; chan_wr = 1; chan_new = 5'd31; cycle();

    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom_range(3) == 0) rand_caps();
      chan_wr  = $urandom_range(1);
      chan_new = 5'($urandom);
      rd_match = $urandom_range(1);
      wr_event = $urandom_range(1);
      clr_mrl  = $urandom_range(2) == 0;
      clr_tdl  = $urandom_range(2) == 0;
      pin_act  = 2'($urandom);
      mrl_a_set = $urandom & $urandom & $urandom;
      mrl_b_set = $urandom & $urandom & $urandom;
      tdl_a_set = $urandom & $urandom & $urandom;
      tdl_b_set = $urandom & $urandom & $urandom;
      cycle();
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule